// File: doc/BRIEF.md
# Audio Playback Sample FIFO with DMA Request

This block is the transmit side of an on-chip audio DAC front end. A DMA engine writes 32-bit sample words into a 64-entry FIFO through a data port. A small register port holds the control fields and clears the status flag. The block asks for more data on a DMA request line. The request follows the FIFO's free space, with two thresholds: one to start requesting and one to stop.

On each sample-rate strobe the block delivers one left and one right 24-bit sample to the DAC path. In stereo mode it takes two entries per strobe, left first and then right. In mono mode it takes one entry and drives it to both channels. Samples are taken either as 24 significant bits of each word or as 16-bit samples. A 16-bit sample has its unused low bits filled with zeros or with copies of its sign bit. When the FIFO has too few entries for a strobe, the block outputs silence or repeats the previous pair, as a control bit selects. It also sets a sticky underrun flag.

Top module: `audio_tx_fifo`

## Requirements
- R1: A control write (reg_addr_i=0) with bit 0 set empties the FIFO: free_o reads 64 on the next cycle and a following strobe finds no data. Bit 0 is not stored.
- R2: drq_o is low while control bit 4 (request enable) is 0, and falls on the cycle after a control write clears that bit.
- R3: With enable set and drq_o low, drq_o rises once free_o is at least the trigger level in control bits 13:8 and at least the stop room.
- R4: Once high, drq_o stays high while free_o is at least the stop room. The stop room is 4*(code+1) free slots, where code is control bits 22:21, so code 3 gives 16. drq_o is never high with fewer than 4 free slots, so a 4-word burst always fits.
- R5: A data write to a full FIFO is discarded.
- R6: Stereo (control bit 6 = 0): each strobe pops two entries, the older one to left_o and the newer one to right_o. smp_valid_o pulses on the cycle after every strobe.
- R7: Mono (control bit 6 = 1): each strobe pops one entry and drives it to both left_o and right_o.
- R8: 16-bit mode (control bit 5 = 0): the sample is word bits 15:0 placed in output bits 23:8. Bits 7:0 are zero when control bit 24 is 0, and copies of word bit 15 when bit 24 is 1.
- R9: 24-bit mode (control bit 5 = 1): the output is word bits 31:8, whatever the value of bit 24.
- R10: Underrun is a strobe that finds fewer entries than it needs (2 in stereo, 1 in mono). It pops nothing. Both outputs become zero if control bit 26 is 0, and keep their previous values if it is 1.
- R11: urun_o sets on an underrun and stays set until a status write (reg_addr_i=1) with bit 0 set. A new underrun in the same cycle wins.
- R12: free_o equals 64 minus the number of stored entries and reads 64 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects control, 1 selects status |
| reg_wdata_i | input | 32 | Register write data |
| data_we_i | input | 1 | Sample word write strobe from DMA |
| data_i | input | 32 | Sample word |
| drq_o | output | 1 | DMA request |
| free_o | output | 7 | Free FIFO slots |
| urun_o | output | 1 | Sticky underrun flag |
| fs_tick_i | input | 1 | Sample-rate strobe, one cycle wide |
| left_o | output | 24 | Left sample to DAC |
| right_o | output | 24 | Right sample to DAC |
| smp_valid_o | output | 1 | New sample pair presented |

## Verification
The assertions check the request rules on every cycle. They check that the request drops after it is disabled, that no request stands with fewer than 4 free slots, and that the free count never exceeds the depth. They also check that a flush leaves the FIFO empty on the next cycle, that each strobe gives exactly one valid pulse, and that the underrun flag stays set until it is cleared. The bench's scenarios are needed for the data path: channel order, mono duplication, the 16-bit and 24-bit packing with both fill modes, zero versus hold on underrun, dropping of writes to a full FIFO, and the request hysteresis between trigger level and stop room.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  typedef struct packed {
    logic       hold_last;
    logic       fill_msb;
    logic [1:0] stop_code;
    logic [5:0] trig;
    logic       mono;
    logic       w24;
    logic       drq_en;
  } tx_ctrl_t;

  function automatic tx_ctrl_t decode_ctrl(input logic [31:0] w);
    tx_ctrl_t c;
    c.hold_last = w[26];
    c.fill_msb  = w[24];
    c.stop_code = w[22:21];
    c.trig      = w[13:8];
    c.mono      = w[6];
    c.w24       = w[5];
    c.drq_en    = w[4];
    return c;
  endfunction

  function automatic logic [23:0] fmt_sample(input logic [31:0] w, input logic w24,
                                             input logic fill_msb);
    if (w24) return w[31:8];
    return {w[15:0], {8{fill_msb & w[15]}}};
  endfunction
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop1_i,
  input  logic          pop2_i,
  output logic [DW-1:0] head0_o,
  output logic [DW-1:0] head1_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok;
  logic [1:0]    npop;

  assign push_ok = push_i && (cnt_q < CW'(DEPTH));
  assign npop    = pop2_i ? 2'd2 : (pop1_i ? 2'd1 : 2'd0);
  assign head0_o = mem_q[rd_q];
  assign head1_o = mem_q[rd_q + AW'(1)];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + AW'(1);
      rd_q  <= rd_q + AW'(npop);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(npop);
    end
  end
endmodule

// File: rtl/tx_drq_ctrl.sv
module tx_drq_ctrl #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [5:0]    trig_i,
  input  logic [1:0]    stop_code_i,
  input  logic [CW-1:0] free_i,
  output logic          drq_o
);
  logic          hold_q;
  logic [CW-1:0] stop_room;

  assign stop_room = CW'({stop_code_i, 2'b00}) + CW'(4);
  // hysteresis: start at trigger level, keep going down to stop room
  assign drq_o = en_i && (free_i >= stop_room) && (hold_q || (free_i >= CW'(trig_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= drq_o;
  end
endmodule

// File: rtl/tx_sample_out.sv
module tx_sample_out #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          mono_i,
  input  logic          w24_i,
  input  logic          fill_msb_i,
  input  logic          hold_last_i,
  input  logic [CW-1:0] count_i,
  input  logic [31:0]   head0_i,
  input  logic [31:0]   head1_i,
  output logic          pop1_o,
  output logic          pop2_o,
  output logic [23:0]   left_o,
  output logic [23:0]   right_o,
  output logic          valid_o,
  output logic          urun_o
);
  import audio_tx_pkg::*;
  logic        have;
  logic [23:0] s0, s1;

  assign have   = mono_i ? (count_i >= CW'(1)) : (count_i >= CW'(2));
  assign pop1_o = tick_i && have && mono_i;
  assign pop2_o = tick_i && have && !mono_i;
  assign urun_o = tick_i && !have;
  assign s0     = fmt_sample(head0_i, w24_i, fill_msb_i);
  assign s1     = fmt_sample(head1_i, w24_i, fill_msb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) begin
        if (have) begin
          left_o  <= s0;
          right_o <= mono_i ? s0 : s1;
        end else if (!hold_last_i) begin
          left_o  <= '0;
          right_o <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          data_we_i,
  input  logic [31:0]   data_i,
  output logic          drq_o,
  output logic [CW-1:0] free_o,
  output logic          urun_o,
  input  logic          fs_tick_i,
  output logic [23:0]   left_o,
  output logic [23:0]   right_o,
  output logic          smp_valid_o
);
  import audio_tx_pkg::*;

  tx_ctrl_t      ctrl_q;
  logic          flush, urun_clr, urun_ev, urun_q;
  logic          pop1, pop2;
  logic [31:0]   head0, head1;
  logic [CW-1:0] count;

  assign flush    = reg_we_i && !reg_addr_i && reg_wdata_i[0];
  assign urun_clr = reg_we_i &&  reg_addr_i && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ctrl_q <= '0;
    else if (reg_we_i && !reg_addr_i) ctrl_q <= decode_ctrl(reg_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       urun_q <= 1'b0;
    else if (urun_ev)  urun_q <= 1'b1;
    else if (urun_clr) urun_q <= 1'b0;
  end

  assign urun_o = urun_q;
  assign free_o = CW'(DEPTH) - count;

  tx_fifo_store #(.DEPTH(DEPTH), .DW(32)) u_store (
    .clk_i, .rst_ni,
    .flush_i (flush),
    .push_i  (data_we_i),
    .data_i  (data_i),
    .pop1_i  (pop1),
    .pop2_i  (pop2),
    .head0_o (head0),
    .head1_o (head1),
    .count_o (count)
  );

  tx_drq_ctrl #(.CW(CW)) u_drq (
    .clk_i, .rst_ni,
    .en_i        (ctrl_q.drq_en),
    .trig_i      (ctrl_q.trig),
    .stop_code_i (ctrl_q.stop_code),
    .free_i      (free_o),
    .drq_o       (drq_o)
  );

  tx_sample_out #(.CW(CW)) u_out (
    .clk_i, .rst_ni,
    .tick_i      (fs_tick_i),
    .mono_i      (ctrl_q.mono),
    .w24_i       (ctrl_q.w24),
    .fill_msb_i  (ctrl_q.fill_msb),
    .hold_last_i (ctrl_q.hold_last),
    .count_i     (count),
    .head0_i     (head0),
    .head1_i     (head1),
    .pop1_o      (pop1),
    .pop2_o      (pop2),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (smp_valid_o),
    .urun_o      (urun_ev)
  );
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic          reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          drq_o,
  input logic [CW-1:0] free_o,
  input logic          urun_o,
  input logic          fs_tick_i,
  input logic          smp_valid_o
);
  a_r1_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && reg_wdata_i[0]) |=> (free_o == CW'(DEPTH)));

  a_r2_drq_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && !reg_wdata_i[4]) |=> !drq_o);

  a_r4_drq_burst_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drq_o |-> (free_o >= CW'(4)));

  a_r12_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o <= CW'(DEPTH));

  a_r6_valid_follows_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_tick_i |=> smp_valid_o);

  a_r6_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_tick_i |=> !smp_valid_o);

  a_r11_urun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urun_o && !(reg_we_i && reg_addr_i && reg_wdata_i[0])) |=> urun_o);
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .drq_o       (drq_o),
  .free_o      (free_o),
  .urun_o      (urun_o),
  .fs_tick_i   (fs_tick_i),
  .smp_valid_o (smp_valid_o)
);

// File: tb/audio_tx_fifo_tb_top.sv
module audio_tx_fifo_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_addr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic        data_we_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        fs_tick_i = 1'b0;
  logic        drq_o, urun_o, smp_valid_o;
  logic [6:0]  free_o;
  logic [23:0] left_o, right_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  audio_tx_fifo dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [31:0] v);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk_i); data_we_i = 1'b1; data_i = w;
    @(negedge clk_i); data_we_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i); fs_tick_i = 1'b1;
    @(negedge clk_i); fs_tick_i = 1'b0;
  endtask

  localparam logic [31:0] FLUSH = 32'h1, W24 = 32'h20, MONO = 32'h40,
                          FILL = 32'h0100_0000, HOLD = 32'h0400_0000, EN = 32'h10;

  task automatic t_reset();
    chk("R12 reset free", 32'(free_o), 32'd64);
    chk("R2 reset drq", 32'(drq_o), 32'd0);
    chk("R11 reset urun", 32'(urun_o), 32'd0);
    chk("R6 reset valid", 32'(smp_valid_o), 32'd0);
  endtask

  task automatic t_stereo();
    wr_reg(0, W24 | FLUSH);
    push(32'hA1B2C3FF); push(32'h44556677);
    chk("R12 free after 2", 32'(free_o), 32'd62);
    tick();
    chk("R6 valid", 32'(smp_valid_o), 32'd1);
    chk("R6 left first", 32'(left_o), 32'h00A1B2C3);
    chk("R9 right 24b", 32'(right_o), 32'h00445566);
    chk("R6 two popped", 32'(free_o), 32'd64);
    @(negedge clk_i);
    chk("R6 valid one cycle", 32'(smp_valid_o), 32'd0);
    wr_reg(0, W24 | FILL);
    push(32'h12345678); push(32'h9ABCDEF0);
    tick();
    chk("R9 fill bit ignored", 32'(left_o), 32'h00123456);
  endtask

  task automatic t_mono_fmt();
    wr_reg(0, MONO);
    push(32'h0000_8123); push(32'h0000_1234);
    tick();
    chk("R8 zero fill", 32'(left_o), 32'h00812300);
    chk("R7 mono dup", 32'(right_o), 32'h00812300);
    chk("R7 one popped", 32'(free_o), 32'd63);
    wr_reg(0, MONO | FILL);
    push(32'h0000_8123);
    tick();
    chk("R8 msb fill positive", 32'(left_o), 32'h00123400);
    tick();
    chk("R8 msb fill negative", 32'(right_o), 32'h008123FF);
  endtask

  task automatic t_underrun();
    wr_reg(1, 32'h1);
    wr_reg(0, W24);
    push(32'hCAFE0000);
    tick();
    chk("R10 zero on underrun", 32'(left_o), 32'h0);
    chk("R10 no pop on underrun", 32'(free_o), 32'd63);
    chk("R11 urun set", 32'(urun_o), 32'd1);
    repeat (3) @(negedge clk_i);
    chk("R11 urun sticky", 32'(urun_o), 32'd1);
    wr_reg(1, 32'h1);
    chk("R11 urun cleared", 32'(urun_o), 32'd0);
    push(32'hBEEF0000);
    tick();
    chk("R6 left after partial", 32'(left_o), 32'h00CAFE00);
    wr_reg(0, W24 | HOLD);
    tick();
    chk("R10 hold left", 32'(left_o), 32'h00CAFE00);
    chk("R10 hold right", 32'(right_o), 32'h00BEEF00);
    wr_reg(1, 32'h1);
  endtask

  task automatic t_flush_full();
    wr_reg(0, W24 | MONO | FLUSH);
    for (int i = 0; i < 64; i++) push(32'(i + 1) << 8);
    chk("R12 full free", 32'(free_o), 32'd0);
    push(32'hDEAD_0000);
    chk("R5 full drop free", 32'(free_o), 32'd0);
    for (int i = 0; i < 64; i++) begin
      tick();
      if (i == 63) chk("R5 last kept entry", 32'(left_o), 32'd64);
    end
    tick();
    chk("R5 extra word dropped", 32'(urun_o), 32'd1);
    wr_reg(1, 32'h1);
    push(32'h11110000); push(32'h22220000);
    wr_reg(0, W24 | MONO | FLUSH);
    chk("R1 flush free", 32'(free_o), 32'd64);
    tick();
    chk("R1 flush underrun", 32'(urun_o), 32'd1);
    wr_reg(1, 32'h1);
  endtask

  task automatic t_drq();
    // trig 15, stop code 3 -> room 16
    wr_reg(0, W24 | EN | (32'd15 << 8) | (32'd3 << 21) | FLUSH);
    chk("R3 drq raised", 32'(drq_o), 32'd1);
    for (int i = 0; i < 48; i++) push(32'h0);
    chk("R4 drq at room 16", 32'(drq_o), 32'd1);
    push(32'h0);
    chk("R4 drq stop below 16", 32'(drq_o), 32'd0);
    tick();
    chk("R3 drq re-raised at 17", 32'(drq_o), 32'd1);
    // trig 40, code 0 -> room 4
    wr_reg(0, W24 | EN | (32'd40 << 8) | FLUSH);
    for (int i = 0; i < 30; i++) push(32'h0);
    chk("R4 hysteresis hold", 32'(drq_o), 32'd1);
    wr_reg(0, W24 | (32'd40 << 8));
    chk("R2 drq off", 32'(drq_o), 32'd0);
    wr_reg(0, W24 | EN | (32'd40 << 8));
    chk("R3 below trig no drq", 32'(drq_o), 32'd0);
    for (int i = 0; i < 3; i++) tick();
    chk("R3 drq at trig 40", 32'(drq_o), 32'd1);
    for (int i = 0; i < 36; i++) push(32'h0);
    chk("R4 drq room 4", 32'(drq_o), 32'd1);
    push(32'h0);
    chk("R4 drq stop room 3", 32'(drq_o), 32'd0);
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_stereo();
    t_mono_fmt();
    t_underrun();
    t_flush_full();
    t_drq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule